// File: doc/BRIEF.md
# Time-Slotted PCM Serial Transceiver

This block carries audio samples for up to three full-duplex channels over one shared serial PCM data line. Each audio frame is split into 1, 2, 4, 8 or 16 slots of 16 bits. Every channel owns one slot, selected by its slot register. It transmits its 13-bit sample in that slot and receives the peer's sample from the same slot. Slots that no enabled channel owns are left undriven, so other devices on the line can use them.

The bit clock and the frame-start strobe come from separate sync logic. The block oversamples both on its system clock. Transmit bits launch on the bit clock's rising edge and receive bits are sampled on its falling edge. Software-visible setup is a set of static inputs:
- the slot-count select;
- the bit order;
- the justification of the 13 sample bits inside the 16-bit slot word;
- the rule for filling the three pad bits on transmit.

The default, with all of these inputs at zero, is left-justified two's complement, sent MSB first, with zero padding.

Top module: `pcm_slot_xcvr`

## Requirements
- R1: The slot count is 2^rate_sel_i for codes 0..4 (1, 2, 4, 8, 16 slots), and codes above 4 give 16 slots. A slot index at or beyond the count is never driven, and a channel whose slot register holds such an index neither transmits nor receives.
- R2: A channel transmits and receives in the slot named by its slot register. If several enabled channels name the same slot, the lowest-numbered one owns it and the others stay silent and report nothing.
- R3: During any slot that no enabled channel owns, sdo_oe_o is low for all 16 bits.
- R4: In an owned slot, sdo_oe_o is high from the rising edge of bit 0 through the high phase of bit 15. It goes low at the falling edge of bit 15.
- R5: The 16-bit slot word is built as follows. With right_just_i=0 the sample occupies bits 15:3 and the pad bits are 2:0. With right_just_i=1 the sample occupies bits 12:0 and the pad bits are 15:13.
- R6: fill_mode_i selects the transmit pad bits: 0 gives zeros, 1 gives ones, 2 gives copies of the sample's sign bit (bit 12), and 3 gives fill_val_i.
- R7: With lsb_first_i=0, word bit 15 is sent first and received first. With lsb_first_i=1, word bit 0 is first. Slot bit k is word bit 15-k or k respectively.
- R8: The received sample is taken from the sample bits only, and pad bits are ignored. After the falling edge of bit 15 it appears on rx_sample_o of the owning channel with a rx_valid_o pulse lasting one clock.
- R9: sdo_o changes only after a bit-clock rising edge and holds through the low phase.
- R10: Transmit samples are captured at the rising edge that carries the frame strobe, including a value applied in that same cycle. Later changes in the frame wait for the next frame.
- R11: After reset, and until the first frame strobe, sdo_oe_o is low, rx_valid_o is zero and rx_sample_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock, synchronous to clk_i |
| fsync_i | input | 1 | Frame-start strobe, sampled at a bit-clock rising edge |
| sdi_i | input | 1 | Serial receive data |
| sdo_o | output | 1 | Serial transmit data |
| sdo_oe_o | output | 1 | Output enable for sdo_o; low means high impedance |
| rate_sel_i | input | 3 | Slot-count select |
| lsb_first_i | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| right_just_i | input | 1 | Sample placement: 0 left, 1 right justified |
| fill_mode_i | input | 2 | Transmit pad-bit rule |
| fill_val_i | input | 3 | Programmed pad value |
| ch_en_i | input | NCH | Channel enables |
| ch_slot_i | input | NCH x 4 | Slot number per channel |
| tx_sample_i | input | NCH x 13 | Transmit sample per channel |
| rx_sample_o | output | NCH x 13 | Received sample per channel |
| rx_valid_o | output | NCH | One-cycle received-sample strobe per channel |

## Verification
Two things happen on the same rising edge: the transmit sample is captured at frame start, and bit 0 of slot 0 is launched. The bench applies fresh tx_sample_i values in the cycle where it raises the bit clock together with the frame strobe. The word serialised in the owned slots must carry those fresh values, and in some frames a further change made one bit later must not appear. On the falling edge of bit 15, the output-enable release and the receive strobe also coincide. Both are judged from the enable sampled in that low phase and from the strobe count and the received value per channel.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  localparam int SLOT_W     = 16;
  localparam int SMP_W      = 13;
  localparam int PAD_W      = SLOT_W - SMP_W;
  localparam int BIT_W      = $clog2(SLOT_W);
  localparam int MAX_SLOTS  = 16;
  localparam int SLOT_IDX_W = $clog2(MAX_SLOTS);
  localparam int SLOT_CNT_W = SLOT_IDX_W + 1;
  localparam int RATE_W     = 3;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_ONE  = 2'd1,
    FILL_SIGN = 2'd2,
    FILL_PROG = 2'd3
  } fill_e;

  typedef logic [SMP_W-1:0]  smp_t;
  typedef logic [SLOT_W-1:0] word_t;

  function automatic word_t pack_slot(smp_t s, logic rj, fill_e m, logic [PAD_W-1:0] v);
    logic [PAD_W-1:0] pad;
    case (m)
      FILL_ZERO: pad = '0;
      FILL_ONE:  pad = '1;
      FILL_SIGN: pad = {PAD_W{s[SMP_W-1]}};
      default:   pad = v;
    endcase
    return rj ? {pad, s} : {s, pad};
  endfunction

  function automatic smp_t unpack_slot(word_t w, logic rj);
    return rj ? w[SMP_W-1:0] : w[SLOT_W-1:PAD_W];
  endfunction
endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
  import pcm_slot_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bclk_i,
  input  logic                  fsync_i,
  input  logic [RATE_W-1:0]     rate_sel_i,
  output logic                  rise_o,
  output logic                  fall_o,
  output logic                  frame_o,
  output logic                  run_o,
  output logic [BIT_W-1:0]      bit_o,
  output logic [BIT_W-1:0]      bit_nxt_o,
  output logic [SLOT_CNT_W-1:0] slot_nxt_o,
  output logic [SLOT_CNT_W-1:0] nslots_o
);
  localparam logic [BIT_W-1:0]      LAST_BIT  = BIT_W'(SLOT_W - 1);
  localparam logic [SLOT_CNT_W-1:0] IDLE_SLOT = SLOT_CNT_W'(MAX_SLOTS);

  logic                  bclk_q;
  logic [BIT_W-1:0]      bit_q;
  logic [SLOT_CNT_W-1:0] slot_q;
  logic                  run_q;

  assign rise_o  = bclk_i & ~bclk_q;
  assign fall_o  = ~bclk_i & bclk_q;
  assign frame_o = rise_o & fsync_i;
  assign run_o   = run_q;
  assign bit_o   = bit_q;

  assign nslots_o = (rate_sel_i >= RATE_W'(SLOT_IDX_W)) ? IDLE_SLOT
                                                         : (SLOT_CNT_W'(1) << rate_sel_i);

  always_comb begin
    bit_nxt_o  = fsync_i ? '0 : bit_q + 1'b1;
    slot_nxt_o = slot_q;
    if (fsync_i)                                   slot_nxt_o = '0;
    else if (bit_q == LAST_BIT && slot_q != IDLE_SLOT) slot_nxt_o = slot_q + 1'b1;
  end

  // slot_q parks at IDLE_SLOT (beyond any slot count) until a frame starts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= 1'b0;
      bit_q  <= LAST_BIT;
      slot_q <= IDLE_SLOT;
      run_q  <= 1'b0;
    end else begin
      bclk_q <= bclk_i;
      if (rise_o) begin
        bit_q  <= bit_nxt_o;
        slot_q <= slot_nxt_o;
        if (fsync_i) run_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx
  import pcm_slot_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int CH_W = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rise_i,
  input  logic                       fall_i,
  input  logic                       frame_i,
  input  logic [BIT_W-1:0]           bit_i,
  input  logic [BIT_W-1:0]           bit_nxt_i,
  input  logic                       own_vld_i,
  input  logic [CH_W-1:0]            own_idx_i,
  input  logic [NCH-1:0][SMP_W-1:0]  tx_sample_i,
  input  logic                       lsb_first_i,
  input  logic                       right_just_i,
  input  fill_e                      fill_mode_i,
  input  logic [PAD_W-1:0]           fill_val_i,
  output logic                       sdo_o,
  output logic                       sdo_oe_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_W - 1);

  smp_t             hold_q [NCH];
  smp_t             src;
  word_t            word;
  logic [BIT_W-1:0] pos;

  for (genvar c = 0; c < NCH; c++) begin : g_hold
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hold_q[c] <= '0;
      else if (frame_i) hold_q[c] <= tx_sample_i[c];
    end
  end

  // the frame-start edge uses the live input so bit 0 carries the new sample
  always_comb begin
    src = '0;
    for (int c = 0; c < NCH; c++)
      if (CH_W'(c) == own_idx_i) src = frame_i ? tx_sample_i[c] : hold_q[c];
  end

  assign word = pack_slot(src, right_just_i, fill_mode_i, fill_val_i);
  assign pos  = lsb_first_i ? bit_nxt_i : LAST_BIT - bit_nxt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else if (rise_i) begin
      sdo_oe_o <= own_vld_i;
      sdo_o    <= own_vld_i & word[pos];
    end else if (fall_i && bit_i == LAST_BIT) begin
      sdo_oe_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_slot_rx.sv
module pcm_slot_rx
  import pcm_slot_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int CH_W = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       fall_i,
  input  logic [BIT_W-1:0]           bit_i,
  input  logic                       own_vld_i,
  input  logic [CH_W-1:0]            own_idx_i,
  input  logic                       sdi_i,
  input  logic                       lsb_first_i,
  input  logic                       right_just_i,
  output logic [NCH-1:0][SMP_W-1:0]  rx_sample_o,
  output logic [NCH-1:0]             rx_valid_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_W - 1);

  word_t            asm_q, asm_nxt;
  logic [BIT_W-1:0] pos;
  logic             done;

  assign pos  = lsb_first_i ? bit_i : LAST_BIT - bit_i;
  assign done = fall_i & own_vld_i & (bit_i == LAST_BIT);

  always_comb begin
    asm_nxt      = asm_q;
    asm_nxt[pos] = sdi_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                asm_q <= '0;
    else if (fall_i && own_vld_i) asm_q <= asm_nxt;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_out
    logic hit;
    assign hit = done && own_idx_i == CH_W'(c);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rx_valid_o[c]  <= 1'b0;
        rx_sample_o[c] <= '0;
      end else begin
        rx_valid_o[c] <= hit;
        if (hit) rx_sample_o[c] <= unpack_slot(asm_nxt, right_just_i);
      end
    end
  end
endmodule

// File: rtl/pcm_slot_xcvr.sv
module pcm_slot_xcvr
  import pcm_slot_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bclk_i,
  input  logic                       fsync_i,
  input  logic                       sdi_i,
  output logic                       sdo_o,
  output logic                       sdo_oe_o,
  input  logic [2:0]                 rate_sel_i,
  input  logic                       lsb_first_i,
  input  logic                       right_just_i,
  input  logic [1:0]                 fill_mode_i,
  input  logic [2:0]                 fill_val_i,
  input  logic [NCH-1:0]             ch_en_i,
  input  logic [NCH-1:0][3:0]        ch_slot_i,
  input  logic [NCH-1:0][12:0]       tx_sample_i,
  output logic [NCH-1:0][12:0]       rx_sample_o,
  output logic [NCH-1:0]             rx_valid_o
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic                  rise, fall, frame, run_q;
  logic [BIT_W-1:0]      bit_cur, bit_nxt;
  logic [SLOT_CNT_W-1:0] slot_nxt, nslots;
  logic                  own_vld, own_vld_q;
  logic [CH_W-1:0]       own_idx, own_idx_q;

  pcm_slot_timer u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bclk_i     (bclk_i),
    .fsync_i    (fsync_i),
    .rate_sel_i (rate_sel_i),
    .rise_o     (rise),
    .fall_o     (fall),
    .frame_o    (frame),
    .run_o      (run_q),
    .bit_o      (bit_cur),
    .bit_nxt_o  (bit_nxt),
    .slot_nxt_o (slot_nxt),
    .nslots_o   (nslots)
  );

  // owner of the slot starting at the next rising edge; lowest index wins
  always_comb begin
    own_vld = 1'b0;
    own_idx = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (ch_en_i[c] && {1'b0, ch_slot_i[c]} == slot_nxt && slot_nxt < nslots) begin
        own_vld = 1'b1;
        own_idx = CH_W'(c);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_vld_q <= 1'b0;
      own_idx_q <= '0;
    end else if (rise) begin
      own_vld_q <= own_vld;
      own_idx_q <= own_idx;
    end
  end

  pcm_slot_tx #(.NCH(NCH), .CH_W(CH_W)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rise_i       (rise),
    .fall_i       (fall),
    .frame_i      (frame),
    .bit_i        (bit_cur),
    .bit_nxt_i    (bit_nxt),
    .own_vld_i    (own_vld),
    .own_idx_i    (own_idx),
    .tx_sample_i  (tx_sample_i),
    .lsb_first_i  (lsb_first_i),
    .right_just_i (right_just_i),
    .fill_mode_i  (fill_e'(fill_mode_i)),
    .fill_val_i   (fill_val_i),
    .sdo_o        (sdo_o),
    .sdo_oe_o     (sdo_oe_o)
  );

  pcm_slot_rx #(.NCH(NCH), .CH_W(CH_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fall_i       (fall),
    .bit_i        (bit_cur),
    .own_vld_i    (own_vld_q),
    .own_idx_i    (own_idx_q),
    .sdi_i        (sdi_i),
    .lsb_first_i  (lsb_first_i),
    .right_just_i (right_just_i),
    .rx_sample_o  (rx_sample_o),
    .rx_valid_o   (rx_valid_o)
  );
endmodule

// File: rtl/pcm_slot_xcvr_chk.sv
module pcm_slot_xcvr_chk #(
  parameter int NCH = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           bclk_i,
  input logic           fsync_i,
  input logic           sdo_o,
  input logic           sdo_oe_o,
  input logic [NCH-1:0] rx_valid_o,
  input logic           run_i
);
  // R9: data moves only on a bit-clock rising edge
  a_r9_sdo_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> $past(bclk_i));

  // R4: enable drops at a falling edge (or a frame restart)
  a_r4_oe_release_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sdo_oe_o) |-> (!$past(bclk_i) || $past(fsync_i)));

  // R3: enable is taken only at a rising edge
  a_r3_oe_take_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(bclk_i));

  // R8: at most one channel strobes, on a falling edge, for one cycle
  a_r8_valid_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rx_valid_o));

  a_r8_valid_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_valid_o) |-> !$past(bclk_i));

  a_r8_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rx_valid_o) |=> !(|rx_valid_o));

  // R11: nothing driven before the first frame
  a_r11_idle_before_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!sdo_oe_o && !(|rx_valid_o)));
endmodule

bind pcm_slot_xcvr pcm_slot_xcvr_chk #(.NCH(NCH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bclk_i     (bclk_i),
  .fsync_i    (fsync_i),
  .sdo_o      (sdo_o),
  .sdo_oe_o   (sdo_oe_o),
  .rx_valid_o (rx_valid_o),
  .run_i      (run_q)
);

// File: tb/pcm_slot_xcvr_test.sv
`timescale 1ns/1ps
module pcm_slot_xcvr_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [2:0] rate = 3'd0;
  logic lsb = 1'b0, rj = 1'b0;
  logic [1:0] fmode = 2'd0;
  logic [2:0] fval = 3'd0;
  logic [2:0] en = 3'b000;
  logic [2:0][3:0] slot = '0;
  logic [2:0][12:0] tx_sample = '0;
  logic [2:0][12:0] rx_sample;
  logic [2:0] rx_valid;

  int vectors = 0, errors = 0;
  int rx_cnt [3];
  logic [12:0] rx_got [3];
  logic [12:0] rx_exp [3];

  always #2.5 clk = ~clk;

  pcm_slot_xcvr uut (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .fsync_i(fsync), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .rate_sel_i(rate), .lsb_first_i(lsb),
    .right_just_i(rj), .fill_mode_i(fmode), .fill_val_i(fval), .ch_en_i(en),
    .ch_slot_i(slot), .tx_sample_i(tx_sample), .rx_sample_o(rx_sample),
    .rx_valid_o(rx_valid)
  );

  always @(negedge clk)
    if (rst_n)
      for (int c = 0; c < 3; c++)
        if (rx_valid[c]) begin
          rx_cnt[c]++;
          rx_got[c] = rx_sample[c];
        end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_ns(input logic [2:0] r);
    return (r >= 3'd4) ? 16 : (1 << r);
  endfunction

  function automatic int owner_of(input int s);
    if (s >= exp_ns(rate)) return -1;
    for (int c = 0; c < 3; c++)
      if (en[c] && int'(slot[c]) == s) return c;
    return -1;
  endfunction

  function automatic logic [15:0] bpack(input logic [12:0] s, input logic r, input logic [1:0] m,
                                        input logic [2:0] v);
    logic [2:0] p;
    case (m)
      2'd0: p = 3'b000;
      2'd1: p = 3'b111;
      2'd2: p = {3{s[12]}};
      default: p = v;
    endcase
    return r ? {p, s} : {s, p};
  endfunction

  task automatic run_frame(input logic [2:0][12:0] tx_new, input bit mid_change);
    int ns = exp_ns(rate);
    int nrun = (ns < 16) ? ns + 1 : 16;
    logic [15:0] gw [16];
    logic [15:0] sdl [16];
    logic [15:0] oeh [16];
    logic [15:0] oel [16];
    logic [15:0] rxw [16];
    for (int c = 0; c < 3; c++) begin
      rx_exp[c] = 13'($urandom);
      rx_cnt[c] = 0;
    end
    for (int s = 0; s < 16; s++) begin
      int o = owner_of(s);
      rxw[s] = (o >= 0) ? bpack(rx_exp[o], rj, 2'd3, 3'($urandom)) : 16'($urandom);
    end
    for (int s = 0; s < nrun; s++)
      for (int b = 0; b < 16; b++) begin
        int pos = lsb ? b : 15 - b;
        @(negedge clk);
        bclk = 1'b1;
        fsync = (s == 0 && b == 0);
        sdi = rxw[s][pos];
        if (s == 0 && b == 0) tx_sample = tx_new;
        if (mid_change && s == 0 && b == 1)
          for (int c = 0; c < 3; c++) tx_sample[c] = ~tx_new[c];
        repeat (3) @(negedge clk);
        gw[s][pos] = sdo;
        oeh[s][b] = sdo_oe;
        @(negedge clk);
        bclk = 1'b0;
        fsync = 1'b0;
        repeat (2) @(negedge clk);
        oel[s][b] = sdo_oe;
        sdl[s][pos] = sdo;
        repeat (2) @(negedge clk);
      end
    for (int s = 0; s < nrun; s++) begin
      int o = owner_of(s);
      if (o >= 0) begin
        logic [15:0] ew = bpack(tx_new[o], rj, fmode, fval);
        chk(gw[s] == ew, "R5 R6 R7 R10 tx word", {16'h0, gw[s]}, {16'h0, ew});
        chk(sdl[s] == gw[s], "R9 data held in low phase", {16'h0, sdl[s]}, {16'h0, gw[s]});
        chk(oeh[s] == 16'hffff, "R4 enable high through slot", {16'h0, oeh[s]}, 32'hffff);
        chk(oel[s] == 16'h7fff, "R4 release at last falling edge", {16'h0, oel[s]}, 32'h7fff);
      end else if (s >= ns) begin
        chk(oeh[s] == 16'h0 && oel[s] == 16'h0, "R1 slot beyond count idle", {16'h0, oeh[s]}, 32'h0);
      end else begin
        chk(oeh[s] == 16'h0 && oel[s] == 16'h0, "R3 unowned slot idle", {16'h0, oeh[s]}, 32'h0);
      end
    end
    for (int c = 0; c < 3; c++) begin
      int want = (owner_of(int'(slot[c])) == c) ? 1 : 0;
      chk(rx_cnt[c] == want, "R2 receive strobe count", rx_cnt[c], want);
      if (want == 1)
        chk(rx_got[c] == rx_exp[c], "R8 received sample", {19'h0, rx_got[c]}, {19'h0, rx_exp[c]});
    end
  endtask

  task automatic random_cfg();
    int ns;
    rate = 3'($urandom_range(0, 5));
    ns = exp_ns(rate);
    lsb = 1'($urandom);
    rj = 1'($urandom);
    fmode = 2'($urandom);
    fval = 3'($urandom);
    for (int c = 0; c < 3; c++) begin
      en[c] = ($urandom_range(0, 3) != 0);
      slot[c] = 4'($urandom_range(0, (ns + 1 > 15) ? 15 : ns + 1));
    end
  endtask

  initial begin
    logic [2:0][12:0] tv;
    void'($urandom(32'h0C0DE5));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sdo_oe == 1'b0, "R11 reset enable", {31'h0, sdo_oe}, 32'h0);
    chk(rx_valid == 3'b0 && rx_sample == '0, "R11 reset receive", {29'h0, rx_valid}, 32'h0);
    en = 3'b001;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); bclk = 1'b1;
      repeat (3) @(negedge clk);
      chk(sdo_oe == 1'b0, "R11 idle before first frame", {31'h0, sdo_oe}, 32'h0);
      @(negedge clk); bclk = 1'b0;
      repeat (3) @(negedge clk);
    end
    // default format, 4 slots
    rate = 3'd2; en = 3'b111;
    slot[0] = 4'd0; slot[1] = 4'd3; slot[2] = 4'd1;
    tv[0] = 13'h1abc; tv[1] = 13'h0123; tv[2] = 13'h1001;
    run_frame(tv, 1'b0);
    // sign fill, right justified, LSB first, change mid-frame
    fmode = 2'd2; rj = 1'b1; lsb = 1'b1;
    tv[0] = 13'h1555; tv[1] = 13'h0aaa; tv[2] = 13'h1f00;
    run_frame(tv, 1'b1);
    // duplicate slot: lowest channel owns, ones fill
    fmode = 2'd1; rj = 1'b0; lsb = 1'b0; slot[1] = 4'd0; slot[2] = 4'd0; en = 3'b110;
    run_frame(tv, 1'b0);
    // single slot, programmed pad, channels beyond count
    rate = 3'd0; fmode = 2'd3; fval = 3'b101; en = 3'b111;
    slot[0] = 4'd1; slot[1] = 4'd0; slot[2] = 4'd2;
    run_frame(tv, 1'b0);
    // clamped code 7 gives 16 slots
    rate = 3'd7; slot[0] = 4'd15; slot[1] = 4'd8; slot[2] = 4'd4;
    run_frame(tv, 1'b1);
    for (int f = 0; f < 22; f++) begin
      random_cfg();
      for (int c = 0; c < 3; c++) tv[c] = 13'($urandom);
      run_frame(tv, 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule